// File: doc/BRIEF.md
# SPI Slave Message Engine

This block lets an external SPI master swap framed messages with the local side of a chip. No local processor takes part in the transfer. The master opens a transaction by pulling chip select low and closes it by releasing it. Each transaction is full duplex and follows a fixed frame:

1. Both ends exchange a status byte. On the slave side the status byte is delayed by one padding byte.
2. Each end then sends a word count.
3. The payload follows as 32-bit words. Payload words travel big-endian and are stored at buffer addresses that count up from zero.

The slave has two 64-word buffers. The transmit buffer is filled from the local side and then marked as queued. An interrupt line tells the master that outgoing data is waiting. The receive buffer is filled by the master. Once it is full, the slave reports it as not ready until the local side releases it.

All of the serial pins are brought into the system-clock domain through two-flop synchronizers. The system clock must run at least four times faster than the serial clock. A configuration input picks which serial-clock edge samples the input line. The output line changes on the other edge and floats while chip select is high.

Top module: `spi_msg_slave`

## Requirements
- R1: A falling `spi_cs_n` starts a transaction at byte 0, bit 0. A rising `spi_cs_n` ends it, at any point.
- R2: With `cfg_sample_fall`=0, `spi_mosi` is sampled on rising `spi_sclk` and `spi_miso` changes on falling edges. With `cfg_sample_fall`=1, the edges are swapped.
- R3: Every byte is shifted most significant bit first in both directions.
- R4: `spi_miso` is high impedance while `spi_cs_n` is high and driven while it is low.
- R5: Outbound byte 0 is 0x00. Outbound byte 1 is the status byte: bit 1 is queued-transmit (TXQ), bit 0 is receive-ready (RDY) = not `rx_full`, and all other bits are 0. Inbound byte 0 is the master status, of which only bit 0 (master ready) is used. Inbound byte 1 is ignored.
- R6: Outbound byte 2 is the queued word count, but only if TXQ is set and the master's inbound bit 0 was 1; otherwise it is 0. From byte 3 on, the slave sends transmit words 0, 1, ... big-endian, and 0x00 after the announced words.
- R7: Inbound byte 2 is accepted as a word count only while RDY=1, and is clamped to 64. Inbound payload words are assembled big-endian and stored at receive addresses 0, 1, ...
- R8: When every accepted word arrives before `spi_cs_n` rises, `rx_full` goes to 1 and `rx_count` takes the count. While `rx_full` is 1, RDY is 0, inbound payload is discarded and the buffer is unchanged. `rx_release` clears `rx_full`.
- R9: When every announced transmit word has been shifted out before `spi_cs_n` rises, TXQ clears. `irq` equals TXQ.
- R10: A transaction that ends early leaves TXQ set and `rx_full` at 0.
- R11: `tx_wr_en` writes the transmit buffer. `tx_queue` with `tx_len` of 1 to 127 sets TXQ and stores min(`tx_len`, 64). Writes and queue requests are ignored while TXQ is set, and a length of 0 is ignored.
- R12: After reset, `irq`=0, `rx_full`=0, `rx_count`=0 and TXQ=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sample_fall | input | 1 | 1: sample on the falling serial edge |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, tri-state |
| irq | output | 1 | Transmit data queued |
| tx_wr_en | input | 1 | Transmit buffer write strobe |
| tx_wr_addr | input | 6 | Transmit buffer word address |
| tx_wr_data | input | 32 | Transmit buffer write data |
| tx_queue | input | 1 | Mark the transmit buffer queued |
| tx_len | input | 7 | Number of words to queue |
| rx_release | input | 1 | Hand the receive buffer back |
| rx_rd_addr | input | 6 | Receive buffer word address |
| rx_rd_data | output | 32 | Receive buffer read data |
| rx_full | output | 1 | Receive buffer holds a message |
| rx_count | output | 7 | Words in the held message |

## Verification
Transmit completion and receive completion are both settled on the same system-clock cycle: the one that sees chip select rise. A full-duplex transaction can therefore clear TXQ and set `rx_full` at once. The bench provokes this by queueing words locally and having the master announce and send words in the same transaction, in both edge modes and at the 64-word clamp. A behavioural model tracks TXQ and RDY on every clock and judges `irq`, `rx_full`, `rx_count` and the received buffer contents. A truncated transaction checks that neither completion fires early.

// File: rtl/spi_msg_pkg.sv
package spi_msg_pkg;
    typedef logic [7:0] octet_t;

    localparam int ST_TXQ_BIT = 1;
    localparam int ST_RDY_BIT = 0;
    localparam int HDR_BYTES  = 3;

    function automatic octet_t status_octet(input logic txq, input logic rdy);
        octet_t s;
        s = '0;
        s[ST_TXQ_BIT] = txq;
        s[ST_RDY_BIT] = rdy;
        return s;
    endfunction
endpackage

// File: rtl/spi_msg_sync.sv
module spi_msg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_start,
    output logic cs_end,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_q, cs_q, mo_q;
    logic              sck_prev_q, cs_prev_q;
    logic              sck, cs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q      <= '0;
            cs_q       <= '1;
            mo_q       <= '0;
            sck_prev_q <= 1'b0;
            cs_prev_q  <= 1'b1;
        end else begin
            sck_q      <= {sck_q[STAGES-2:0], sclk_i};
            cs_q       <= {cs_q[STAGES-2:0], cs_n_i};
            mo_q       <= {mo_q[STAGES-2:0], mosi_i};
            sck_prev_q <= sck;
            cs_prev_q  <= cs;
        end
    end

    assign sck       = sck_q[STAGES-1];
    assign cs        = cs_q[STAGES-1];
    assign mosi_s    = mo_q[STAGES-1];
    assign sclk_rise = sck & ~sck_prev_q;
    assign sclk_fall = ~sck & sck_prev_q;
    assign cs_start  = ~cs & cs_prev_q;
    assign cs_end    = cs & ~cs_prev_q;
endmodule

// File: rtl/spi_msg_wordbuf.sv
module spi_msg_wordbuf #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_msg_slave.sv
module spi_msg_slave
    import spi_msg_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int SYNC   = 2,
    localparam int AW    = $clog2(WORDS),
    localparam int LW    = AW + 1,
    localparam int IDXW  = $clog2(HDR_BYTES + 4 * WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_sample_fall,
    input  logic          spi_sclk,
    input  logic          spi_cs_n,
    input  logic          spi_mosi,
    output wire           spi_miso,
    output logic          irq,
    input  logic          tx_wr_en,
    input  logic [AW-1:0] tx_wr_addr,
    input  logic [31:0]   tx_wr_data,
    input  logic          tx_queue,
    input  logic [LW-1:0] tx_len,
    input  logic          rx_release,
    input  logic [AW-1:0] rx_rd_addr,
    output logic [31:0]   rx_rd_data,
    output logic          rx_full,
    output logic [LW-1:0] rx_count
);
    typedef struct packed {
        logic            active;
        logic [2:0]      bitcnt;
        logic [IDXW-1:0] idx;
        octet_t          rx_sh;
        octet_t          tx_sh;
        logic            txq;
        logic [LW-1:0]   tx_len;
        logic [LW-1:0]   tx_go;
        logic [LW-1:0]   tx_done;
        logic            rx_full;
        logic [LW-1:0]   rx_count;
        logic [LW-1:0]   rx_len;
        logic [LW-1:0]   rx_done;
        logic [23:0]     rx_acc;
    } st_t;

    st_t q, d;

    logic sclk_rise, sclk_fall, cs_start, cs_end, mosi_s;
    logic samp_edge, shift_edge;
    logic rx_we;
    logic [AW-1:0] rx_waddr;
    logic [31:0]   rx_wdata, tx_rdata;
    logic tx_we;
    logic [IDXW-1:0] pay;
    logic [IDXW-3:0] wsel;
    logic [1:0]      bsel;
    octet_t          inb, outb, tx_pick;

    function automatic logic [LW-1:0] clamp_len(input octet_t n);
        if (int'(n) > WORDS) return LW'(WORDS);
        return LW'(n);
    endfunction

    spi_msg_sync #(.STAGES(SYNC)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_start(cs_start), .cs_end(cs_end), .mosi_s(mosi_s)
    );

    spi_msg_wordbuf #(.DEPTH(WORDS), .WIDTH(32)) i_txbuf (
        .clk(clk), .we(tx_we), .waddr(tx_wr_addr), .wdata(tx_wr_data),
        .raddr(wsel[AW-1:0]), .rdata(tx_rdata)
    );

    spi_msg_wordbuf #(.DEPTH(WORDS), .WIDTH(32)) i_rxbuf (
        .clk(clk), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
        .raddr(rx_rd_addr), .rdata(rx_rd_data)
    );

    assign samp_edge  = cfg_sample_fall ? sclk_fall : sclk_rise;
    assign shift_edge = cfg_sample_fall ? sclk_rise : sclk_fall;
    assign pay        = q.idx - IDXW'(HDR_BYTES);
    assign wsel       = pay[IDXW-1:2];
    assign bsel       = pay[1:0];
    assign inb        = {q.rx_sh[6:0], mosi_s};

    always_comb begin
        case (bsel)
            2'd0:    tx_pick = tx_rdata[31:24];
            2'd1:    tx_pick = tx_rdata[23:16];
            2'd2:    tx_pick = tx_rdata[15:8];
            default: tx_pick = tx_rdata[7:0];
        endcase
        if (q.idx == IDXW'(0))      outb = 8'h00;
        else if (q.idx == IDXW'(1)) outb = status_octet(q.txq, !q.rx_full);
        else if (q.idx == IDXW'(2)) outb = 8'(q.tx_go);
        else if (int'(wsel) < int'(q.tx_go)) outb = tx_pick;
        else                        outb = 8'h00;
    end

    always_comb begin
        d        = q;
        rx_we    = 1'b0;
        rx_waddr = '0;
        rx_wdata = '0;
        tx_we    = tx_wr_en && !q.txq;

        if (tx_queue && !q.txq && tx_len != '0) begin
            d.txq    = 1'b1;
            d.tx_len = (int'(tx_len) > WORDS) ? LW'(WORDS) : tx_len;
        end
        if (rx_release) d.rx_full = 1'b0;

        if (cs_start) begin
            d.active  = 1'b1;
            d.bitcnt  = '0;
            d.idx     = '0;
            d.tx_sh   = '0;
            d.tx_go   = '0;
            d.tx_done = '0;
            d.rx_len  = '0;
            d.rx_done = '0;
        end else if (cs_end) begin
            d.active = 1'b0;
            d.tx_sh  = '0;
            if (q.tx_go != '0 && q.tx_done == q.tx_go) d.txq = 1'b0;
            if (q.rx_len != '0 && q.rx_done == q.rx_len) begin
                d.rx_full  = 1'b1;
                d.rx_count = q.rx_len;
            end
        end else if (q.active) begin
            if (samp_edge) begin
                d.rx_sh  = inb;
                d.bitcnt = q.bitcnt + 3'd1;
                if (q.bitcnt == 3'd7) begin
                    if (q.idx != '1) d.idx = q.idx + IDXW'(1);
                    if (q.idx == IDXW'(0)) begin
                        d.tx_go = (q.txq && inb[ST_RDY_BIT]) ? q.tx_len : '0;
                    end else if (q.idx == IDXW'(2)) begin
                        d.rx_len = q.rx_full ? '0 : clamp_len(inb);
                    end else if (q.idx > IDXW'(2)) begin
                        d.rx_acc = {q.rx_acc[15:0], inb};
                        if (bsel == 2'd3) begin
                            if (int'(wsel) < int'(q.rx_len)) begin
                                rx_we     = 1'b1;
                                rx_waddr  = wsel[AW-1:0];
                                rx_wdata  = {q.rx_acc, inb};
                                d.rx_done = q.rx_done + LW'(1);
                            end
                            if (int'(wsel) < int'(q.tx_go)) d.tx_done = q.tx_done + LW'(1);
                        end
                    end
                end
            end
            if (shift_edge) begin
                d.tx_sh = (q.bitcnt == 3'd0) ? outb : {q.tx_sh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign spi_miso = spi_cs_n ? 1'bz : q.tx_sh[7];
    assign irq      = q.txq;
    assign rx_full  = q.rx_full;
    assign rx_count = q.rx_count;

    // TXQ only drops on the cycle after a chip-select release
    p_txq_clear_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.txq) |-> $past(cs_end));

    // receive buffer only becomes full on a transaction end
    p_rxfull_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rx_full) |-> $past(cs_end));

    // no payload write lands in a held receive buffer
    p_no_write_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> !q.rx_full);

    // every transaction restarts framing at byte 0, bit 0
    p_frame_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_start |=> (q.idx == '0 && q.bitcnt == 3'd0));

    // accepted count never exceeds the buffer depth
    p_len_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.rx_len) <= WORDS);

    // queued length is frozen while TXQ holds
    p_queue_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.txq && d.txq) |=> $stable(q.tx_len));
endmodule

// File: tb/test_spi_msg_slave.sv
module test_spi_msg_slave;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_sample_fall = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    wire  miso_w;
    logic irq, rx_full;
    logic tx_wr_en = 1'b0, tx_queue = 1'b0, rx_release = 1'b0;
    logic [5:0] tx_wr_addr = '0, rx_rd_addr = '0;
    logic [31:0] tx_wr_data = '0, rx_rd_data;
    logic [6:0] tx_len = '0, rx_count;

    int checks = 0, errors = 0;
    bit mon_en = 1'b0;

    // behavioural model
    bit m_txq = 0, m_rdy = 1;
    int m_len = 0, m_cnt = 0;
    logic [31:0] m_tx [64];
    logic [31:0] m_rx [64];
    logic [31:0] mpl  [64];

    pullup (miso_w);

    spi_msg_slave i_spi_msg_slave (
        .clk(clk), .rst_n(rst_n), .cfg_sample_fall(cfg_sample_fall),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(miso_w), .irq(irq),
        .tx_wr_en(tx_wr_en), .tx_wr_addr(tx_wr_addr), .tx_wr_data(tx_wr_data),
        .tx_queue(tx_queue), .tx_len(tx_len), .rx_release(rx_release),
        .rx_rd_addr(rx_rd_addr), .rx_rd_data(rx_rd_data),
        .rx_full(rx_full), .rx_count(rx_count)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n) chk("R4", {31'b0, miso_w}, 32'd1);
            if (mon_en) begin
                chk("R9", {31'b0, irq}, {31'b0, m_txq});
                chk("R8", {31'b0, rx_full}, {31'b0, !m_rdy});
            end
        end
    end

    // R2 R3: one byte, MSB first, edge order set by cfg_sample_fall
    task automatic spi_byte(input logic [7:0] ob, output logic [7:0] ib);
        for (int i = 7; i >= 0; i--) begin
            if (!cfg_sample_fall) begin
                spi_mosi = ob[i];
                repeat (HALF) @(negedge clk);
                ib[i] = miso_w;
                spi_sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                spi_sclk = 1'b0;
            end else begin
                spi_sclk = 1'b1;
                spi_mosi = ob[i];
                repeat (HALF) @(negedge clk);
                ib[i] = miso_w;
                spi_sclk = 1'b0;
                repeat (HALF) @(negedge clk);
            end
        end
    endtask

    task automatic readback_rx();
        for (int w = 0; w < m_cnt; w++) begin
            rx_rd_addr = w[5:0];
            @(negedge clk);
            chk("R7 R8", rx_rd_data, m_rx[w]);
        end
    endtask

    task automatic xact(input logic [7:0] mstat, input int mlen, input int nbytes);
        logic [7:0] so, got, ob, st;
        int go, rlen, w, b;
        bit rx_done;
        mon_en = 1'b0;
        st   = {6'b0, m_txq, m_rdy};
        go   = (m_txq && mstat[0]) ? m_len : 0;
        rlen = m_rdy ? ((mlen > 64) ? 64 : mlen) : 0;
        spi_cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4", {31'b0, miso_w}, 32'd0);
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < nbytes; k++) begin
            if (k == 0)      begin ob = mstat;      so = 8'h00; end
            else if (k == 1) begin ob = 8'h00;      so = st; end
            else if (k == 2) begin ob = mlen[7:0];  so = go[7:0]; end
            else begin
                w  = (k - 3) / 4;
                b  = (k - 3) % 4;
                ob = mpl[w][31-8*b -: 8];
                so = (w < go) ? m_tx[w][31-8*b -: 8] : 8'h00;
            end
            spi_byte(ob, got);
            chk((k < 2) ? "R3 R5" : "R3 R6", {24'b0, got}, {24'b0, so});
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        repeat (6) @(negedge clk);
        // R1 R10: completion only when every announced word went through
        if (go > 0 && nbytes >= 3 + 4 * go) m_txq = 0;
        rx_done = (rlen > 0 && nbytes >= 3 + 4 * rlen);
        if (rx_done) begin
            m_rdy = 0;
            m_cnt = rlen;
            for (int i = 0; i < rlen; i++) m_rx[i] = mpl[i];
        end
        chk("R9 R10", {31'b0, irq}, {31'b0, m_txq});
        chk("R8 R10", {31'b0, rx_full}, {31'b0, !m_rdy});
        chk("R8", {25'b0, rx_count}, m_cnt);
        if (rx_done) readback_rx();
        mon_en = 1'b1;
    endtask

    task automatic lwrite(input int a, input logic [31:0] v);
        @(negedge clk);
        tx_wr_en = 1'b1; tx_wr_addr = a[5:0]; tx_wr_data = v;
        @(negedge clk);
        tx_wr_en = 1'b0;
        if (!m_txq) m_tx[a] = v;
    endtask

    task automatic lqueue(input int n);
        mon_en = 1'b0;
        @(negedge clk);
        tx_queue = 1'b1; tx_len = n[6:0];
        @(negedge clk);
        tx_queue = 1'b0;
        if (!m_txq && n != 0) begin
            m_txq = 1;
            m_len = (n > 64) ? 64 : n;
        end
        @(negedge clk);
        chk("R11", {31'b0, irq}, {31'b0, m_txq});
        mon_en = 1'b1;
    endtask

    task automatic lrelease();
        mon_en = 1'b0;
        @(negedge clk); rx_release = 1'b1;
        @(negedge clk); rx_release = 1'b0;
        m_rdy = 1;
        @(negedge clk);
        chk("R8", {31'b0, rx_full}, 32'd0);
        mon_en = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mpl[i] = 32'h1000_0000 + i * 32'h0103_0507;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", {31'b0, irq}, 32'd0);
        chk("R12", {31'b0, rx_full}, 32'd0);
        chk("R12", {25'b0, rx_count}, 32'd0);
        mon_en = 1'b1;

        // R5: bare status exchange, nothing queued
        xact(8'h00, 0, 3);

        // R11: fill and queue three words, then try to overwrite and requeue
        for (int i = 0; i < 3; i++) lwrite(i, 32'hA5C3_0000 + i * 32'h0011_2233);
        lqueue(3);
        lwrite(0, 32'hDEAD_BEEF);
        lqueue(5);
        lqueue(0);

        // R6: master not ready, slave must announce 0 and keep TXQ
        xact(8'h00, 0, 7);
        // R6 R9: master ready, three words leave, TXQ clears
        xact(8'h01, 0, 3 + 12);

        // R7 R8: master delivers two words
        for (int i = 0; i < 64; i++) mpl[i] = 32'h7700_0000 + i * 32'h0102_0305;
        xact(8'h02, 2, 11);
        // R8: buffer held, new payload must be ignored
        for (int i = 0; i < 64; i++) mpl[i] = 32'h3C00_0000 ^ (i * 32'h0909_0101);
        xact(8'h02, 2, 11);
        readback_rx();
        lrelease();

        // R10: cut short inside word 1 in both directions
        lwrite(0, 32'h0BAD_F00D);
        lwrite(1, 32'h1234_5678);
        lqueue(2);
        xact(8'h03, 2, 9);

        // R1 R2: fresh frame in the other edge mode, full duplex completion
        cfg_sample_fall = 1'b1;
        repeat (4) @(negedge clk);
        xact(8'h03, 2, 11);
        lrelease();

        // R7 R11: 64-word clamp both ways in the same transaction
        cfg_sample_fall = 1'b0;
        for (int i = 0; i < 64; i++) lwrite(i, 32'hF000_0000 - i * 32'h0101_0001);
        lqueue(90);
        for (int i = 0; i < 64; i++) mpl[i] = 32'h5A5A_0000 + i * 32'h0003_0011;
        xact(8'h03, 100, 3 + 256);
        lrelease();

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule